// File: doc/BRIEF.md
# Pixel Cluster Finder (3x3 window)

The block takes a raster stream of pixel samples from a fixed-size frame, row 0 first and column 0 first within a row. Two line buffers hold the previous two rows, so each new pixel completes a 3x3 window whose centre sits one row and one column behind it. Each complete window is judged by three criteria. The first is a seed cut on the centre pixel. The second compares the cluster charge against a programmable multiple of a single noise constant. The third is a shape cut: the centre must dominate the sum of its eight neighbours by a programmable fixed-point factor.

When a window passes all three criteria, a shared restoring divider computes the charge-weighted position of the cluster relative to its centre. It runs first for X and then for Y, producing one quotient bit per cycle. During that time the input is held off. The finished record holds the centre coordinates, the nine-pixel sum and two signed sub-pixel offsets. It is presented under a valid/ready handshake.

The controller has five states. SCAN accepts pixels. It moves to JUDGE when the accepted pixel completes an interior window. JUDGE returns to SCAN on a reject, or moves to DIVX when all criteria pass. DIVX moves to DIVY when the X quotient is done. DIVY moves to EMIT when the Y quotient is done. EMIT returns to SCAN once the record is taken.

Top module: `cluster_finder`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: Pixels arrive in raster order. Record coordinates are out_x = column and out_y = row of the window centre, counted from 0. Records leave in raster order of their centres.
- R3: A window whose centre is in column 0, column COLS-1, row 0 or row ROWS-1 is never reported.
- R4: The centre value must be strictly greater than cfg_seed.
- R5: The nine-pixel sum must be strictly greater than cfg_level × cfg_noise.
- R6: centre × 256 must be strictly greater than cfg_shape × (sum of the eight neighbours). cfg_shape is unsigned with 8 fractional bits, so 0x0100 means 1.0.
- R7: out_sum is the sum of all nine pixel values of the accepted window.
- R8: out_dx is the right column sum minus the left column sum, times 256, divided by out_sum, truncated toward zero. It is two's complement, 8 fractional bits, and lies within −256..256. out_dy is formed the same way from the lower row (higher y) minus the upper row.
- R9: While out_valid is 1 and out_ready is 0, the record holds stable. in_ready is 0 from the cycle after a window is completed until its record is taken or rejected.
- R10: After COLS×ROWS accepted pixels, the position counters wrap, and the next pixel is column 0, row 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel sample valid |
| in_ready | output | 1 | Block can take a pixel |
| in_pix | input | PW | Pixel value |
| cfg_seed | input | PW | Seed threshold for the centre pixel |
| cfg_noise | input | PW | Noise constant |
| cfg_level | input | LW | Signal-to-noise multiplier |
| cfg_shape | input | SHW | Shape factor, 8 fractional bits |
| out_valid | output | 1 | Cluster record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_x | output | clog2(COLS) | Centre column |
| out_y | output | clog2(ROWS) | Centre row |
| out_sum | output | PW+4 | Nine-pixel sum |
| out_dx | output | 10 | X offset, two's complement, 8 fractional bits |
| out_dy | output | 10 | Y offset, two's complement, 8 fractional bits |

## Verification
The bench runs several patterns on a reduced 8x6 frame and compares every emitted record with a model built from the requirement text:
- A lone peak checks the basic record and the sum.
- Peaks on the frame edges show that border centres are dropped, while their interior neighbours are still judged.
- Pairs of peaks set exactly on, and one count above, the seed, signal-to-noise and shape limits show that each comparison is strict.
- Lopsided clusters give offsets of both signs and fix the truncation direction.
- A stalled consumer and two back-to-back frames cover record holding and counter wrap.

// File: rtl/cf_pkg.sv
package cf_pkg;

    localparam int FRAC = 8;

    typedef enum logic [2:0] {
        ST_SCAN,
        ST_JUDGE,
        ST_DIVX,
        ST_DIVY,
        ST_EMIT
    } cf_state_e;

endpackage

// File: rtl/cf_window.sv
module cf_window #(
    parameter int COLS = 512,
    parameter int ROWS = 512,
    parameter int PW   = 14,
    localparam int XW  = $clog2(COLS),
    localparam int YW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift,
    input  logic [PW-1:0] pix,
    output logic          cand_now,
    output logic [XW-1:0] cen_x,
    output logic [YW-1:0] cen_y,
    output logic [PW-1:0] win [3][3]
);

    logic [XW-1:0] col_q;
    logic [YW-1:0] row_q;
    logic [PW-1:0] line_a [COLS];
    logic [PW-1:0] line_b [COLS];
    logic [PW-1:0] tap [3];

    // the incoming pixel completes a window with an interior centre
    assign cand_now = (col_q >= XW'(2)) && (row_q >= YW'(2));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
            cen_x <= '0;
            cen_y <= '0;
        end else if (shift) begin
            cen_x <= col_q - XW'(1);
            cen_y <= row_q - YW'(1);
            if (col_q == XW'(COLS - 1)) begin
                col_q <= '0;
                row_q <= (row_q == YW'(ROWS - 1)) ? '0 : row_q + YW'(1);
            end else begin
                col_q <= col_q + XW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (shift) begin
            line_a[col_q] <= pix;
            line_b[col_q] <= line_a[col_q];
        end
    end

    assign tap[0] = line_b[col_q];
    assign tap[1] = line_a[col_q];
    assign tap[2] = pix;

    for (genvar r = 0; r < 3; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win[r][0] <= '0;
                win[r][1] <= '0;
                win[r][2] <= '0;
            end else if (shift) begin
                win[r][0] <= win[r][1];
                win[r][1] <= win[r][2];
                win[r][2] <= tap[r];
            end
        end
    end

    a_r10_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (col_q <= XW'(COLS - 1)) && (row_q <= YW'(ROWS - 1)));

endmodule

// File: rtl/cf_judge.sv
module cf_judge #(
    parameter int PW  = 14,
    parameter int LW  = 8,
    parameter int SHW = 16,
    localparam int SW = PW + 4,
    localparam int KW = (LW + PW > SW) ? LW + PW : SW,
    localparam int MW = SHW + SW
) (
    input  logic [PW-1:0]  win [3][3],
    input  logic [PW-1:0]  seed,
    input  logic [PW-1:0]  noise,
    input  logic [LW-1:0]  level,
    input  logic [SHW-1:0] shape,
    output logic           pass,
    output logic [SW-1:0]  sum,
    output logic [SW-1:0]  magx,
    output logic           negx,
    output logic [SW-1:0]  magy,
    output logic           negy
);

    logic [SW-1:0] col_sum [3];
    logic [SW-1:0] row_sum [3];
    logic [SW-1:0] ring;
    logic [KW-1:0] snr_floor, sum_k;
    logic [MW-1:0] shape_lhs, shape_rhs;
    logic          ok_seed, ok_snr, ok_shape;

    for (genvar k = 0; k < 3; k++) begin : g_line
        assign col_sum[k] = SW'(win[0][k]) + SW'(win[1][k]) + SW'(win[2][k]);
        assign row_sum[k] = SW'(win[k][0]) + SW'(win[k][1]) + SW'(win[k][2]);
    end

    assign sum  = col_sum[0] + col_sum[1] + col_sum[2];
    assign ring = sum - SW'(win[1][1]);

    always_comb begin
        snr_floor = KW'(level) * KW'(noise);
        sum_k     = KW'(sum);
        shape_lhs = MW'({win[1][1], 8'h00});
        shape_rhs = MW'(shape) * MW'(ring);
        ok_seed   = win[1][1] > seed;
        ok_snr    = sum_k > snr_floor;
        ok_shape  = shape_lhs > shape_rhs;
        pass      = ok_seed && ok_snr && ok_shape;
        negx = col_sum[2] < col_sum[0];
        magx = negx ? col_sum[0] - col_sum[2] : col_sum[2] - col_sum[0];
        negy = row_sum[2] < row_sum[0];
        magy = negy ? row_sum[0] - row_sum[2] : row_sum[2] - row_sum[0];
    end

endmodule

// File: rtl/cf_divider.sv
module cf_divider #(
    parameter int DW   = 18,
    parameter int FRAC = 8,
    localparam int QW  = FRAC + 1,
    localparam int CW  = $clog2(QW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          busy,
    output logic          done,
    output logic [QW-1:0] quo
);

    logic [DW:0]   rem_q;
    logic [DW-1:0] den_q;
    logic [CW-1:0] cnt_q;
    logic          ge;
    logic [DW:0]   rem_nxt;

    always_comb begin
        ge      = rem_q >= {1'b0, den_q};
        rem_nxt = ge ? rem_q - {1'b0, den_q} : rem_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
            quo   <= '0;
        end else if (start) begin
            rem_q <= {1'b0, num};
            den_q <= den;
            cnt_q <= CW'(QW);
            busy  <= 1'b1;
            done  <= 1'b0;
            quo   <= '0;
        end else begin
            done <= busy && (cnt_q == CW'(1));
            if (busy) begin
                quo   <= {quo[QW-2:0], ge};
                rem_q <= {rem_nxt[DW-1:0], 1'b0};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) busy <= 1'b0;
            end
        end
    end

    // R8: numerator never exceeds the divisor, so the quotient is at most one
    a_r8_quot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (quo <= QW'(1 << FRAC)) && !busy);

endmodule

// File: rtl/cluster_finder.sv
module cluster_finder #(
    parameter int COLS = 512,
    parameter int ROWS = 512,
    parameter int PW   = 14,
    parameter int LW   = 8,
    parameter int SHW  = 16,
    localparam int XW  = $clog2(COLS),
    localparam int YW  = $clog2(ROWS),
    localparam int SW  = PW + 4,
    localparam int QW  = cf_pkg::FRAC + 1,
    localparam int OW  = cf_pkg::FRAC + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [PW-1:0]  in_pix,
    input  logic [PW-1:0]  cfg_seed,
    input  logic [PW-1:0]  cfg_noise,
    input  logic [LW-1:0]  cfg_level,
    input  logic [SHW-1:0] cfg_shape,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [XW-1:0]  out_x,
    output logic [YW-1:0]  out_y,
    output logic [SW-1:0]  out_sum,
    output logic [OW-1:0]  out_dx,
    output logic [OW-1:0]  out_dy
);
    import cf_pkg::*;

    cf_state_e     state_q, state_d;
    logic          shift, cand_now;
    logic [PW-1:0] win [3][3];
    logic          pass, negx, negy;
    logic [SW-1:0] sum, magx, magy;
    logic          div_start, div_busy, div_done;
    logic [SW-1:0] div_num, div_den;
    logic [QW-1:0] quo;

    logic [SW-1:0] sum_q, magy_q;
    logic          negx_q, negy_q;
    logic [QW-1:0] qx_q, qy_q;

    assign shift = in_valid && in_ready;

    cf_window #(.COLS(COLS), .ROWS(ROWS), .PW(PW)) u_win (
        .clk(clk), .rst_n(rst_n), .shift(shift), .pix(in_pix),
        .cand_now(cand_now), .cen_x(out_x), .cen_y(out_y), .win(win)
    );

    cf_judge #(.PW(PW), .LW(LW), .SHW(SHW)) u_judge (
        .win(win), .seed(cfg_seed), .noise(cfg_noise), .level(cfg_level),
        .shape(cfg_shape), .pass(pass), .sum(sum),
        .magx(magx), .negx(negx), .magy(magy), .negy(negy)
    );

    assign div_start = (state_q == ST_JUDGE && pass) || (state_q == ST_DIVX && div_done);
    assign div_num   = (state_q == ST_JUDGE) ? magx : magy_q;
    assign div_den   = (state_q == ST_JUDGE) ? sum  : sum_q;

    cf_divider #(.DW(SW), .FRAC(FRAC)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num), .den(div_den),
        .busy(div_busy), .done(div_done), .quo(quo)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SCAN;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SCAN:  if (in_valid && cand_now) state_d = ST_JUDGE;
            ST_JUDGE: state_d = pass ? ST_DIVX : ST_SCAN;
            ST_DIVX:  if (div_done) state_d = ST_DIVY;
            ST_DIVY:  if (div_done) state_d = ST_EMIT;
            ST_EMIT:  if (out_ready) state_d = ST_SCAN;
            default:  state_d = ST_SCAN;
        endcase
    end

    // handshake outputs
    always_comb begin
        in_ready  = (state_q == ST_SCAN);
        out_valid = (state_q == ST_EMIT);
    end

    // record datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q  <= '0;
            magy_q <= '0;
            negx_q <= 1'b0;
            negy_q <= 1'b0;
            qx_q   <= '0;
            qy_q   <= '0;
        end else begin
            if (state_q == ST_JUDGE && pass) begin
                sum_q  <= sum;
                magy_q <= magy;
                negx_q <= negx;
                negy_q <= negy;
            end
            if (state_q == ST_DIVX && div_done) qx_q <= quo;
            if (state_q == ST_DIVY && div_done) qy_q <= quo;
        end
    end

    assign out_sum = sum_q;
    assign out_dx  = negx_q ? OW'(0) - OW'(qx_q) : OW'(qx_q);
    assign out_dy  = negy_q ? OW'(0) - OW'(qy_q) : OW'(qy_q);

    a_r9_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y)
            && $stable(out_sum) && $stable(out_dx) && $stable(out_dy));

    a_r9_input_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    a_r3_interior_only: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_x != '0 && out_x != XW'(COLS - 1)
                   && out_y != '0 && out_y != YW'(ROWS - 1));

    a_r8_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $signed(out_dx) <= $signed(OW'(256)) && $signed(out_dx) >= -$signed(OW'(256))
                   && $signed(out_dy) <= $signed(OW'(256)) && $signed(out_dy) >= -$signed(OW'(256)));

    a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(div_busy && out_valid));

endmodule

// File: tb/sim_cluster_finder.sv
module sim_cluster_finder;

    localparam int C = 8;
    localparam int R = 6;

    typedef struct {
        int x; int y; int s; int dx; int dy;
    } rec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [13:0] in_pix = '0;
    logic [13:0] cfg_seed = 14'd10;
    logic [13:0] cfg_noise = 14'd4;
    logic [7:0]  cfg_level = 8'd5;
    logic [15:0] cfg_shape = 16'h0100;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [2:0]  out_x;
    logic [2:0]  out_y;
    logic [17:0] out_sum;
    logic [9:0]  out_dx;
    logic [9:0]  out_dy;

    int pix [R][C];
    rec_t got [$];
    rec_t exp_q [$];
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cluster_finder #(.COLS(C), .ROWS(R)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .cfg_seed(cfg_seed), .cfg_noise(cfg_noise),
        .cfg_level(cfg_level), .cfg_shape(cfg_shape), .out_valid(out_valid),
        .out_ready(out_ready), .out_x(out_x), .out_y(out_y), .out_sum(out_sum),
        .out_dx(out_dx), .out_dy(out_dy)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            rec_t r;
            r.x = int'(out_x); r.y = int'(out_y); r.s = int'(out_sum);
            r.dx = int'($signed(out_dx)); r.dy = int'($signed(out_dy));
            got.push_back(r);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    task automatic clear_frame();
        for (int y = 0; y < R; y++)
            for (int x = 0; x < C; x++) pix[y][x] = 0;
    endtask

    // model built from R2..R8
    task automatic build_expected();
        exp_q.delete();
        for (int y = 1; y < R - 1; y++) begin
            for (int x = 1; x < C - 1; x++) begin
                int s, c, lft, rgt, top, bot, q;
                rec_t e;
                s = 0; lft = 0; rgt = 0; top = 0; bot = 0;
                c = pix[y][x];
                for (int j = -1; j <= 1; j++) begin
                    for (int i = -1; i <= 1; i++) begin
                        s += pix[y+j][x+i];
                        if (i == -1) lft += pix[y+j][x+i];
                        if (i == 1)  rgt += pix[y+j][x+i];
                        if (j == -1) top += pix[y+j][x+i];
                        if (j == 1)  bot += pix[y+j][x+i];
                    end
                end
                if (c > int'(cfg_seed) && s > int'(cfg_level) * int'(cfg_noise)
                    && longint'(c) * 256 > longint'(cfg_shape) * longint'(s - c)) begin
                    e.x = x; e.y = y; e.s = s;
                    q = ((rgt > lft ? rgt - lft : lft - rgt) * 256) / s;
                    e.dx = (rgt < lft) ? -q : q;
                    q = ((bot > top ? bot - top : top - bot) * 256) / s;
                    e.dy = (bot < top) ? -q : q;
                    exp_q.push_back(e);
                end
            end
        end
    endtask

    task automatic send_frame();
        for (int y = 0; y < R; y++) begin
            for (int x = 0; x < C; x++) begin
                bit rdy;
                in_valid = 1'b1;
                in_pix = 14'(pix[y][x]);
                do begin
                    rdy = in_ready;
                    @(negedge clk);
                end while (!rdy);
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic hold_watch();
        int hx, hs, hdx;
        while (!out_valid) @(negedge clk);
        hx = int'(out_x); hs = int'(out_sum); hdx = int'(out_dx);
        repeat (5) @(negedge clk);
        // R9: record unchanged while the consumer stalls
        check(out_valid && !in_ready, "R9 held valid", int'(out_valid), 1);
        check(int'(out_x) == hx && int'(out_sum) == hs && int'(out_dx) == hdx,
              "R9 held fields", int'(out_sum), hs);
        out_ready = 1'b1;
    endtask

    task automatic run_frame(input string req, input bit stall);
        build_expected();
        got.delete();
        if (stall) begin
            out_ready = 1'b0;
            fork
                send_frame();
                hold_watch();
            join
        end else begin
            send_frame();
        end
        repeat (60) @(negedge clk);
        check(got.size() == exp_q.size(), {req, " record count"}, got.size(), exp_q.size());
        for (int k = 0; k < got.size() && k < exp_q.size(); k++) begin
            check(got[k].x == exp_q[k].x && got[k].y == exp_q[k].y,
                  {req, " R2 position"}, got[k].y * 16 + got[k].x, exp_q[k].y * 16 + exp_q[k].x);
            check(got[k].s == exp_q[k].s, {req, " R7 sum"}, got[k].s, exp_q[k].s);
            check(got[k].dx == exp_q[k].dx, {req, " R8 dx"}, got[k].dx, exp_q[k].dx);
            check(got[k].dy == exp_q[k].dy, {req, " R8 dy"}, got[k].dy, exp_q[k].dy);
        end
    endtask

    task automatic t_reset();
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    endtask

    task automatic t_single();
        clear_frame();
        cfg_seed = 10; cfg_noise = 4; cfg_level = 5; cfg_shape = 16'h0100;
        pix[2][3] = 100; pix[2][2] = 10; pix[1][3] = 5; pix[3][4] = 30;
        run_frame("R7 single", 1'b0);
        check(got.size() >= 1, "R2 single found", got.size(), 1);
    endtask

    task automatic t_border();
        clear_frame();
        pix[3][0] = 500; pix[1][7] = 500; pix[0][4] = 500; pix[5][2] = 500;
        run_frame("R3 border", 1'b0);
        check(got.size() == 0, "R3 no border record", got.size(), 0);
    endtask

    task automatic t_seed_edge();
        clear_frame();
        cfg_seed = 40; cfg_noise = 1; cfg_level = 1; cfg_shape = 16'h0100;
        pix[1][1] = 40;  // equal to seed: rejected
        pix[3][5] = 41;  // one above: accepted
        run_frame("R4 seed", 1'b0);
        check(got.size() == 1, "R4 strict seed", got.size(), 1);
    endtask

    task automatic t_snr_edge();
        clear_frame();
        cfg_seed = 10; cfg_noise = 4; cfg_level = 10; cfg_shape = 16'h0100;
        pix[1][2] = 30; pix[1][1] = 10;  // sum 40 == floor
        pix[4][5] = 31; pix[4][6] = 10;  // sum 41 > floor
        run_frame("R5 snr", 1'b0);
        check(got.size() == 1, "R5 strict snr", got.size(), 1);
    endtask

    task automatic t_shape_edge();
        clear_frame();
        cfg_seed = 10; cfg_noise = 1; cfg_level = 1; cfg_shape = 16'h0100;
        pix[1][2] = 64; pix[2][2] = 64;  // centre*256 == shape*ring
        pix[3][5] = 65; pix[4][5] = 64;  // one above
        run_frame("R6 shape", 1'b0);
        check(got.size() == 1, "R6 strict shape", got.size(), 1);
    endtask

    task automatic t_centroid();
        clear_frame();
        cfg_seed = 20; cfg_noise = 2; cfg_level = 10; cfg_shape = 16'h0080;
        pix[2][2] = 100; pix[2][1] = 40; pix[1][2] = 20; pix[3][3] = 30;
        pix[3][5] = 200; pix[3][6] = 50; pix[4][5] = 70; pix[2][4] = 15;
        run_frame("R8 centroid", 1'b0);
        check(got.size() == 2, "R8 two clusters", got.size(), 2);
    endtask

    task automatic t_stall();
        clear_frame();
        cfg_seed = 10; cfg_noise = 1; cfg_level = 1; cfg_shape = 16'h0100;
        pix[2][3] = 300; pix[2][4] = 90; pix[4][2] = 120;
        run_frame("R9 stall", 1'b1);
    endtask

    task automatic t_two_frames();
        clear_frame();
        cfg_seed = 10; cfg_noise = 1; cfg_level = 1; cfg_shape = 16'h0100;
        pix[1][1] = 77; pix[4][6] = 55; pix[3][6] = 11;
        run_frame("R10 frame A", 1'b0);
        run_frame("R10 frame B", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_border();
        t_seed_edge();
        t_snr_edge();
        t_shape_edge();
        t_centroid();
        t_stall();
        t_two_frames();
        summary();
        $finish;
    end

endmodule